// File: doc/BRIEF.md
# Quadrature Phase Balance Meter

This block measures how far two square waves, I and Q, are from an exact quarter-period offset. Each clock cycle the pair is in one of four combined states. The block sorts every cycle into one of two classes. In the "same" class, I and Q have equal levels. In the "diff" class, their levels differ. It keeps one counter for each class. With a perfect 90-degree relationship, each class takes half of every period. Any difference between the two counts therefore shows the phase error.

Both inputs pass through a two-flop synchroniser. After reset the meter stays idle until the synchronised Q has been low and then rises. Counting starts on that rising edge. The block then runs back-to-back gate intervals of `gateLen` clock cycles each, for example 80,000,000 cycles for one second at 80 MHz. At the end of each interval it latches both counts into output registers, pulses `valid` for one cycle, and starts the next interval from zero.

Top module: `quad_balance_meter`

## Requirements
- R1: While `rstN` is low, `cntSame`, `cntDiff` and `valid` are 0. No interval is in progress when reset is released.
- R2: `iIn` and `qIn` each pass through two flops before they are classified. A level driven before clock edge k is first counted in the cycle that starts at edge k+1. With `gateLen` = 1, the first report appears after edge k+2.
- R3: After reset, nothing is counted and no report is made until the synchronised Q has been seen low and then high. The first counted cycle is the one in which synchronised Q first reads high.
- R4: A counted cycle adds one to the same count when the synchronised I and Q are equal, and one to the diff count when they differ.
- R5: Each report covers exactly max(`gateLen`,1) consecutive counted cycles, so `cntSame` + `cntDiff` equals that length. For 50%-duty square waves of period P, with Q delayed d cycles from I and a gate of N·P cycles, `cntDiff` = 2·N·min(d, P−d).
- R6: `valid` is high for exactly one cycle per interval. Successive pulses are max(`gateLen`,1) cycles apart.
- R7: Counting restarts from zero after each report, and the final cycle of an interval is included in that interval's report. Consecutive reports on a steady periodic input are identical.
- R8: A `gateLen` of 0 or 1 gives one-cycle intervals, with a report on every counted cycle.
- R9: `cntSame` and `cntDiff` change only in the cycle in which `valid` is high, and hold their values in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| iIn | input | 1 | In-phase square wave, asynchronous |
| qIn | input | 1 | Quadrature square wave, asynchronous |
| gateLen | input | CNT_W | Interval length in clock cycles |
| cntSame | output | CNT_W | Cycles with I equal to Q in the last interval |
| cntDiff | output | CNT_W | Cycles with I unequal to Q in the last interval |
| valid | output | 1 | One-cycle pulse when new counts are presented |

## Verification
Two functions meet in the last cycle of every interval. That cycle must still be counted, and in the same cycle the counters must be latched and cleared. An off-by-one error at the boundary would lose or repeat that cycle. The sweep exercises this by varying the period and the Q delay with gates of whole periods, so the final cycle lands in either class. Each report is judged against the closed-form counts, and the sum must match the gate length. Gate lengths of 0 and 1 are a harsher test, because there every counted cycle is also an interval boundary.

// File: rtl/qbm_pkg.sv
package qbm_pkg;
  typedef enum logic [1:0] {
    ARM_LOW  = 2'd0,
    ARM_HIGH = 2'd1,
    RUN      = 2'd2
  } qbmState_t;

  typedef struct packed {
    logic countEn;
    logic latch;
  } qbmStrobe_t;
endpackage

// File: rtl/qbm_sync.sv
module qbm_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [STAGES-1:0] chain [WIDTH];

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain[b] <= '0;
      else       chain[b] <= {chain[b][STAGES-2:0], asyncIn[b]};
    end
    assign syncOut[b] = chain[b][STAGES-1];
  end
endmodule

// File: rtl/qbm_ctrl.sv
module qbm_ctrl
  import qbm_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             qSync,
  input  logic [CNT_W-1:0] gateLen,
  output qbmStrobe_t       strobe
);
  qbmState_t        state, stateNext;
  logic [CNT_W-1:0] gatePos, posNow;
  logic             counting, lastCycle;

  always_comb begin
    counting = (state == RUN) || (state == ARM_HIGH && qSync);
    posNow   = (state == RUN) ? gatePos : '0;
    lastCycle = counting && (({1'b0, posNow} + 1'b1) >= {1'b0, gateLen});
    strobe.countEn = counting;
    strobe.latch   = lastCycle;
    stateNext = state;
    case (state)
      ARM_LOW:  if (!qSync) stateNext = ARM_HIGH;
      ARM_HIGH: if (qSync)  stateNext = RUN;
      default:  stateNext = RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ARM_LOW;
      gatePos <= '0;
    end else begin
      state <= stateNext;
      if (counting) gatePos <= lastCycle ? '0 : posNow + 1'b1;
    end
  end
endmodule

// File: rtl/qbm_datapath.sv
module qbm_datapath
  import qbm_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             iSync,
  input  logic             qSync,
  input  qbmStrobe_t       strobe,
  output logic [CNT_W-1:0] cntSame,
  output logic [CNT_W-1:0] cntDiff,
  output logic             valid
);
  logic [CNT_W-1:0] accSame, accDiff, sumSame, sumDiff;
  logic             incSame, incDiff;

  always_comb begin
    incSame = strobe.countEn && (iSync == qSync);
    incDiff = strobe.countEn && (iSync != qSync);
    sumSame = accSame + CNT_W'(incSame);
    sumDiff = accDiff + CNT_W'(incDiff);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accSame <= '0;
      accDiff <= '0;
      cntSame <= '0;
      cntDiff <= '0;
      valid   <= 1'b0;
    end else begin
      valid <= strobe.latch;
      if (strobe.latch) begin
        cntSame <= sumSame;
        cntDiff <= sumDiff;
        accSame <= '0;
        accDiff <= '0;
      end else begin
        accSame <= sumSame;
        accDiff <= sumDiff;
      end
    end
  end
endmodule

// File: rtl/quad_balance_meter.sv
module quad_balance_meter
  import qbm_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int SYNC_DEPTH = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             iIn,
  input  logic             qIn,
  input  logic [CNT_W-1:0] gateLen,
  output logic [CNT_W-1:0] cntSame,
  output logic [CNT_W-1:0] cntDiff,
  output logic             valid
);
  logic [1:0] pairSync;
  logic       iSync, qSync;
  qbmStrobe_t strobe;

  qbm_sync #(.WIDTH(2), .STAGES(SYNC_DEPTH)) u_sync (
    .clk(clk), .rstN(rstN), .asyncIn({qIn, iIn}), .syncOut(pairSync)
  );
  assign iSync = pairSync[0];
  assign qSync = pairSync[1];

  qbm_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .qSync(qSync), .gateLen(gateLen), .strobe(strobe)
  );

  qbm_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .iSync(iSync), .qSync(qSync), .strobe(strobe),
    .cntSame(cntSame), .cntDiff(cntDiff), .valid(valid)
  );
endmodule

// File: rtl/qbm_checker.sv
module qbm_checker
  import qbm_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic [CNT_W-1:0] gateLen,
  input logic [CNT_W-1:0] cntSame,
  input logic [CNT_W-1:0] cntDiff,
  input logic             valid,
  input logic             qSync,
  input qbmStrobe_t       strobe
);
  // R6
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (valid && gateLen > 1) |=> !valid);

  // R5
  sum_matches_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    valid |-> (({1'b0, cntSame} + {1'b0, cntDiff}) ==
               (($past(gateLen) == '0) ? (CNT_W+1)'(1) : {1'b0, $past(gateLen)})));

  // R9
  hold_between_chk: assert property (@(posedge clk) disable iff (!rstN)
    !valid |-> ($stable(cntSame) && $stable(cntDiff)));

  // R3
  arm_on_q_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.countEn && !$past(strobe.countEn)) |-> qSync);
endmodule

bind quad_balance_meter qbm_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .gateLen(gateLen), .cntSame(cntSame),
  .cntDiff(cntDiff), .valid(valid), .qSync(qSync), .strobe(strobe)
);

// File: tb/quad_balance_meter_test.sv
module quad_balance_meter_test;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             iIn = 1'b0;
  logic             qIn = 1'b0;
  logic [CNT_W-1:0] gateLen = '0;
  logic [CNT_W-1:0] cntSame, cntDiff;
  logic             valid;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  genOn   = 1'b0;
  int  per     = 4;
  int  dly     = 0;
  int  tick    = 0;
  int  cycles  = 0;

  quad_balance_meter #(.CNT_W(CNT_W)) uut (
    .clk(clk), .rstN(rstN), .iIn(iIn), .qIn(qIn), .gateLen(gateLen),
    .cntSame(cntSame), .cntDiff(cntDiff), .valid(valid)
  );

  always #5 clk = ~clk;

  always @(negedge clk) begin
    cycles++;
    if (genOn) begin
      iIn = (tick % per) < per / 2;
      qIn = ((tick + per - dly) % per) < per / 2;
      tick++;
    end
  end

  task automatic check(input string req, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    genOn = 1'b0;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic runCase(input int p, input int d, input int n);
    int g, diffExp, gap, seen, lastS, lastD;
    bit holdOk;
    g = n * p;
    diffExp = 2 * n * ((d < p - d) ? d : p - d);
    per = p; dly = d; tick = 0;
    gateLen = CNT_W'(g);
    doReset();
    genOn = 1'b1;
    seen = 0; gap = 0; holdOk = 1'b1; lastS = 0; lastD = 0;
    for (int c = 0; c < 6 * g + 20 && seen < 3; c++) begin
      @(negedge clk);
      gap++;
      if (valid) begin
        // R4 R5 R7: closed-form counts on every report
        check("R5", "cntDiff", cntDiff, diffExp);
        check("R4", "cntSame", cntSame, g - diffExp);
        if (seen > 0) begin
          // R6: pulse spacing
          check("R6", "valid spacing", gap, g);
          // R7: repeated report
          check("R7", "repeat same", cntSame, lastS);
        end
        lastS = cntSame; lastD = cntDiff;
        seen++; gap = 0;
      end else if (seen > 0) begin
        if (cntSame != lastS || cntDiff != lastD) holdOk = 1'b0;
      end
    end
    check("R6", "reports seen", seen, 3);
    // R9
    check("R9", "hold between reports", holdOk, 1);
  endtask

  initial begin
    // R1: reset state
    rstN = 1'b0;
    iIn = 1'b1; qIn = 1'b1; gateLen = CNT_W'(1);
    repeat (3) @(negedge clk);
    check("R1", "valid in reset", valid, 0);
    check("R1", "cntSame in reset", cntSame, 0);
    check("R1", "cntDiff in reset", cntDiff, 0);

    // R3: Q held low, I toggling: no report
    iIn = 1'b0; qIn = 1'b0;
    rstN = 1'b1;
    begin
      int nv = 0;
      for (int c = 0; c < 30; c++) begin
        @(negedge clk);
        iIn = ~iIn;
        if (valid) nv++;
      end
      check("R3", "reports while Q low", nv, 0);
    end

    // R2: latency from Q rise to first report, gate 1
    iIn = 1'b1; qIn = 1'b1;
    @(negedge clk);
    check("R2", "valid after 1 edge", valid, 0);
    @(negedge clk);
    check("R2", "valid after 2 edges", valid, 0);
    @(negedge clk);
    check("R2", "valid after 3 edges", valid, 1);
    check("R8", "cntSame gate 1", cntSame, 1);
    check("R8", "cntDiff gate 1", cntDiff, 0);
    @(negedge clk);
    check("R8", "valid every cycle", valid, 1);

    // R4: I low, Q high gives diff
    iIn = 1'b0;
    repeat (3) @(negedge clk);
    check("R4", "diff class cntDiff", cntDiff, 1);
    check("R4", "diff class cntSame", cntSame, 0);

    // R8: gate length 0 acts as 1
    gateLen = '0;
    repeat (2) @(negedge clk);
    check("R8", "gate 0 valid", valid, 1);
    check("R8", "gate 0 sum", cntSame + cntDiff, 1);

    // R5 R6 R7 R9: sweep period and delay
    for (int p = 4; p <= 8; p += 2)
      for (int d = 0; d < p; d++)
        runCase(p, d, (d % 2) + 1);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual %0d expected 0", cycles);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule